// File: doc/BRIEF.md
# Serial memory page write committer with region locking

This unit sits behind the serial front end of a small byte-addressed non-volatile memory. While the host streams a write or lock transfer, the front end hands over each complete byte. The unit keeps those bytes in a one-page staging buffer. When chip select rises, it decides whether the transfer earned a commit. A commit needs the rise to land exactly on a byte boundary, at least one whole data byte, a write-enable latch that was set when the transfer opened, and a write-protect pin that stayed high for the whole transfer.

A committed array transfer runs a self-timed cycle of `WR_CLKS` clocks with `busy` high. During the first `PAGE_BYTES` clocks of that cycle the unit walks the staged page and presents one byte per clock on the array write port. It skips bytes it never received and bytes whose address falls inside the currently locked region. A committed lock transfer instead loads a 3-bit region code at the end of the cycle. Every committed cycle ends with a one-clock pulse that clears the host's write-enable latch.

Top module: `pgw_commit`

## Requirements
- R1: After reset `busy`, `mem_we` and `wel_clr` are low and `lock_code` is 0.
- R2: A commit raises `busy` on the clock after the `cs_rise` strobe and holds it for exactly `WR_CLKS` clocks. The staged byte at page offset k is written in busy clock k (k counted from 0), at address {page, k}, in ascending offset order.
- R3: The 4-bit page offset starts at the low bits of `xfer_addr` and advances by one per data byte, wrapping from 15 to 0 inside the same page. A later byte at an offset replaces the earlier one, and each offset is written at most once per cycle.
- R4: A `cs_rise` with `cs_on_boundary` low, or with no complete data byte received, discards the transfer: no busy, no array write, no `wel_clr`.
- R5: If `wel` is low when the transfer opens, the transfer is never committed.
- R6: If `wp_n` is low at any clock while the transfer is open, including the `cs_rise` clock, the transfer is discarded. Changes of `wp_n` while `busy` is high do not affect the running cycle.
- R7: Lock codes block these array addresses: 0 none, 1 000h-07Fh, 2 080h-0FFh, 3 100h-17Fh, 4 180h-1FFh, 5 000h-0FFh, 6 000h-00Fh, 7 1F0h-1FFh.
- R8: The lock check is applied per byte with the code in force at commit. Blocked bytes are not written, and `lock_code` stays stable during an array cycle.
- R9: A lock transfer (`xfer_kind`=1) stores bits 2:0 of the last complete byte received. Bits 7:3 are ignored. `lock_code` changes on the same clock on which `busy` falls.
- R10: `wel_clr` pulses high for one clock, on the first clock after `busy` falls, once per committed cycle.
- R11: `xfer_start` and data bytes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Strobe: a write or lock transfer opens |
| xfer_kind | input | 1 | 0 = array write, 1 = lock update |
| xfer_addr | input | 9 | Start byte address of an array transfer |
| byte_vld | input | 1 | Strobe: one complete data byte received |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Strobe: chip select went high |
| cs_on_boundary | input | 1 | Chip select rose right after bit 0 of a byte |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| wel | input | 1 | Write-enable latch state |
| mem_we | output | 1 | Array byte write enable |
| mem_addr | output | 9 | Array byte address |
| mem_wdata | output | 8 | Array byte data |
| lock_code | output | 3 | Region lock code in force |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_clr | output | 1 | One-clock pulse clearing the write-enable latch |

## Verification
The strobes are driven on falling edges, so `cs_rise` is seen by the next rising edge. `busy` is therefore first seen high at the falling edge that follows, and the bench counts busy clocks from that point. A write at page offset k is due in busy clock k. The new `lock_code` and the `wel_clr` pulse are due at the first falling edge where `busy` is low again. The bench samples a lock code in the middle of the cycle to confirm it has not yet changed. A falling-edge monitor logs every write together with its busy-clock index, so order and timing are checked against these counts. Every scenario also waits `WR_CLKS` plus a margin before it judges that something did not happen.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic {
        XFER_ARRAY = 1'b0,
        XFER_LOCK  = 1'b1
    } xfer_kind_e;

    // region codes; the numeric value is the stored encoding
    typedef enum logic [2:0] {
        LK_NONE     = 3'd0,
        LK_QUAD0    = 3'd1,
        LK_QUAD1    = 3'd2,
        LK_QUAD2    = 3'd3,
        LK_QUAD3    = 3'd4,
        LK_LOW_HALF = 3'd5,
        LK_FIRST_PG = 3'd6,
        LK_LAST_PG  = 3'd7
    } lock_code_e;

    typedef struct packed {
        logic       open;     // transfer in progress
        logic       kind;     // xfer_kind_e value
        logic       armed;    // write enable latch seen at open
        logic       abort;    // write protect went low while open
        logic       got;      // at least one complete byte
        logic [2:0] shadow;   // last lock byte, bits 2:0
        logic [2:0] lock;     // lock code in force
    } ctl_t;

endpackage

// File: rtl/pgw_lock_map.sv
module pgw_lock_map #(
    parameter int ADDR_W = 9,
    parameter int OFF_W  = 4
) (
    input  logic [2:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import pgw_pkg::*;

    localparam int PG_W = ADDR_W - OFF_W;

    logic [1:0]      quad;
    logic [PG_W-1:0] page;

    always_comb begin
        quad = addr[ADDR_W-1 -: 2];
        page = addr[ADDR_W-1:OFF_W];
        case (code)
            LK_QUAD0:    locked = (quad == 2'd0);
            LK_QUAD1:    locked = (quad == 2'd1);
            LK_QUAD2:    locked = (quad == 2'd2);
            LK_QUAD3:    locked = (quad == 2'd3);
            LK_LOW_HALF: locked = ~addr[ADDR_W-1];
            LK_FIRST_PG: locked = (page == '0);
            LK_LAST_PG:  locked = (page == '1);
            default:     locked = 1'b0;
        endcase
    end

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        load_addr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [OFF_W-1:0]         rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic [ADDR_W-OFF_W-1:0]  page_base
);

    typedef struct packed {
        logic [OFF_W-1:0]                   ptr;
        logic [ADDR_W-OFF_W-1:0]            base;
        logic [PAGE_BYTES-1:0]              valid;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d.ptr   = load_addr[OFF_W-1:0];
            buf_d.base  = load_addr[ADDR_W-1:OFF_W];
            buf_d.valid = '0;
        end else if (wr_en) begin
            buf_d.data[buf_q.ptr]  = wr_data;
            buf_d.valid[buf_q.ptr] = 1'b1;
            buf_d.ptr              = buf_q.ptr + 1'b1;   // wraps inside the page
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rd_data   = buf_q.data[rd_idx];
    assign rd_valid  = buf_q.valid[rd_idx];
    assign page_base = buf_q.base;

    // a staged byte always marks its slot valid
    p_byte_marks_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load) |=> (buf_q.valid != '0));

endmodule

// File: rtl/pgw_wr_timer.sv
module pgw_wr_timer #(
    parameter int WR_CLKS = 40,
    parameter int CNT_W   = $clog2(WR_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_end;

    assign at_end = tmr_q.busy && (int'(tmr_q.cnt) == WR_CLKS - 1);

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (tmr_q.busy) begin
            if (at_end) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (go) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign last = at_end;
    assign cnt  = tmr_q.cnt;
    assign done = tmr_q.done;

    p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> !busy);

    p_clr_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

endmodule

// File: rtl/pgw_commit.sv
module pgw_commit #(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int WR_CLKS    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_kind,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    input  logic              wp_n,
    input  logic              wel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [2:0]        lock_code,
    output logic              busy,
    output logic              wel_clr
);
    import pgw_pkg::*;

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int CNT_W = $clog2(WR_CLKS);

    ctl_t ctl_d, ctl_q;

    logic             t_busy, t_last, t_done, go;
    logic [CNT_W-1:0] t_cnt;
    logic             accept_start, accept_byte;
    logic [OFF_W-1:0] scan_idx;
    logic [DATA_W-1:0] st_data;
    logic             st_valid, in_scan, addr_locked;
    logic [PG_W-1:0]  page_base;

    assign accept_start = xfer_start && !t_busy;
    assign accept_byte  = byte_vld && ctl_q.open && !t_busy && !xfer_start;

    assign go = cs_rise && ctl_q.open && cs_on_boundary && ctl_q.got
             && ctl_q.armed && !ctl_q.abort && wp_n && !t_busy;

    always_comb begin
        ctl_d = ctl_q;
        if (accept_start) begin
            ctl_d.open  = 1'b1;
            ctl_d.kind  = xfer_kind;
            ctl_d.armed = wel;
            ctl_d.abort = !wp_n;
            ctl_d.got   = 1'b0;
        end else if (ctl_q.open) begin
            if (!wp_n) ctl_d.abort = 1'b1;
            if (accept_byte) begin
                ctl_d.got = 1'b1;
                if (ctl_q.kind == XFER_LOCK) ctl_d.shadow = byte_data[2:0];
            end
            if (cs_rise) ctl_d.open = 1'b0;
        end
        if (t_last && (ctl_q.kind == XFER_LOCK)) ctl_d.lock = ctl_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pgw_wr_timer #(
        .WR_CLKS (WR_CLKS),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .busy  (t_busy),
        .last  (t_last),
        .cnt   (t_cnt),
        .done  (t_done)
    );

    assign scan_idx = t_cnt[OFF_W-1:0];

    pgw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept_start),
        .load_addr (xfer_addr),
        .wr_en     (accept_byte && (ctl_q.kind == XFER_ARRAY)),
        .wr_data   (byte_data),
        .rd_idx    (scan_idx),
        .rd_data   (st_data),
        .rd_valid  (st_valid),
        .page_base (page_base)
    );

    pgw_lock_map #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_map (
        .code   (ctl_q.lock),
        .addr   (mem_addr),
        .locked (addr_locked)
    );

    assign in_scan   = t_busy && (int'(t_cnt) < PAGE_BYTES);
    assign mem_addr  = {page_base, scan_idx};
    assign mem_wdata = st_data;
    assign mem_we    = in_scan && (ctl_q.kind == XFER_ARRAY) && st_valid && !addr_locked;
    assign lock_code = ctl_q.lock;
    assign busy      = t_busy;
    assign wel_clr   = t_done;

    p_we_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_lock_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ctl_q.kind == XFER_ARRAY)) |=> $stable(lock_code));

    p_start_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_start) |=> $stable(page_base));

    p_no_start_on_cs_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctl_q.open) |=> !busy);

endmodule

// File: tb/sim_pgw_commit.sv
module sim_pgw_commit;
    localparam int WR = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 0, xfer_kind = 0, byte_vld = 0, cs_rise = 0, cs_on_boundary = 0;
    logic wp_n = 1, wel = 1;
    logic [8:0] xfer_addr = '0;
    logic [7:0] byte_data = '0;
    logic mem_we, busy, wel_clr;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [2:0] lock_code;

    int checks = 0, errors = 0;
    int wr_count, busy_cnt, clr_cnt, bidx, first_bidx;
    logic [8:0] first_addr;
    logic [7:0] shadow [0:511];
    logic       written [0:511];

    always #5 clk = ~clk;

    pgw_commit #(.WR_CLKS(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_kind(xfer_kind),
        .xfer_addr(xfer_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary), .wp_n(wp_n), .wel(wel),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .lock_code(lock_code), .busy(busy), .wel_clr(wel_clr));

    always @(negedge clk) begin
        if (busy) begin
            if (mem_we) begin
                if (wr_count == 0) begin first_addr = mem_addr; first_bidx = bidx; end
                if (written[mem_addr]) begin
                    errors++; $display("FAIL R3 address %h written twice (act 2 exp 1)", mem_addr);
                end
                shadow[mem_addr]  = mem_wdata;
                written[mem_addr] = 1'b1;
                wr_count++;
            end
            bidx++; busy_cnt++;
        end else bidx = 0;
        if (wel_clr) clr_cnt++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk);
        wr_count = 0; busy_cnt = 0; clr_cnt = 0; first_bidx = -1; first_addr = '0;
        for (int i = 0; i < 512; i++) written[i] = 1'b0;
    endtask

    task automatic open_xfer(logic kind, logic [8:0] a);
        @(negedge clk); xfer_start = 1; xfer_kind = kind; xfer_addr = a;
        @(negedge clk); xfer_start = 0;
    endtask

    task automatic put_byte(logic [7:0] b);
        @(negedge clk); byte_vld = 1; byte_data = b;
        @(negedge clk); byte_vld = 0;
    endtask

    task automatic close_xfer(logic on_bound);
        @(negedge clk); cs_rise = 1; cs_on_boundary = on_bound;
        @(negedge clk); cs_rise = 0; cs_on_boundary = 0;
        repeat (WR + 4) @(negedge clk);
    endtask

    task automatic set_lock(logic [7:0] b);
        clear_log();
        open_xfer(1'b1, '0); put_byte(b); close_xfer(1'b1);
    endtask

    function automatic bit blocked(int code, int a);
        case (code)
            1: return a <= 'h7F;
            2: return a >= 'h80 && a <= 'hFF;
            3: return a >= 'h100 && a <= 'h17F;
            4: return a >= 'h180;
            5: return a <= 'hFF;
            6: return a <= 'hF;
            7: return a >= 'h1F0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 busy", busy, 0); check("R1 mem_we", mem_we, 0);
        check("R1 wel_clr", wel_clr, 0); check("R1 lock_code", lock_code, 0);
    endtask

    task automatic t_basic();
        clear_log();
        open_xfer(1'b0, 9'h123);
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
        close_xfer(1'b1);
        check("R2 write count", wr_count, 3);
        check("R2 busy length", busy_cnt, WR);
        check("R2 first addr", first_addr, 'h123);
        check("R2 first busy clock", first_bidx, 3);
        check("R2 data 123", shadow[9'h123], 'h11);
        check("R2 data 125", shadow[9'h125], 'h33);
        check("R10 clear pulses", clr_cnt, 1);
    endtask

    task automatic t_wrap();
        clear_log();
        open_xfer(1'b0, 9'h13E);
        for (int i = 0; i < 18; i++) put_byte(8'hA0 + 8'(i));
        close_xfer(1'b1);
        check("R3 write count", wr_count, 16);
        check("R3 first addr", first_addr, 'h130);
        check("R3 offset E overwritten", shadow[9'h13E], 'hB0);
        check("R3 offset F overwritten", shadow[9'h13F], 'hB1);
        check("R3 offset 0", shadow[9'h130], 'hA2);
        check("R3 offset D", shadow[9'h13D], 'hAF);
    endtask

    task automatic t_discard();
        clear_log();
        open_xfer(1'b0, 9'h040); put_byte(8'h55); close_xfer(1'b0);
        check("R4 off boundary busy", busy_cnt, 0);
        check("R4 off boundary writes", wr_count, 0);
        open_xfer(1'b0, 9'h040); close_xfer(1'b1);
        check("R4 no byte busy", busy_cnt, 0);
        check("R4 no clear", clr_cnt, 0);
        wel = 0;
        open_xfer(1'b0, 9'h040); put_byte(8'h55);
        wel = 1;
        close_xfer(1'b1);
        check("R5 latch low writes", wr_count, 0);
        check("R5 latch low busy", busy_cnt, 0);
    endtask

    task automatic t_wp();
        clear_log();
        open_xfer(1'b0, 9'h050); put_byte(8'h66);
        @(negedge clk); wp_n = 0; cs_rise = 1; cs_on_boundary = 1;
        @(negedge clk); wp_n = 1; cs_rise = 0; cs_on_boundary = 0;
        repeat (WR + 4) @(negedge clk);
        check("R6 wp at close", busy_cnt, 0);
        open_xfer(1'b0, 9'h050); put_byte(8'h66);
        @(negedge clk); wp_n = 0; @(negedge clk); wp_n = 1;
        put_byte(8'h67); close_xfer(1'b0 | 1'b1);
        check("R6 wp pulse mid transfer", wr_count, 0);
        clear_log();
        open_xfer(1'b0, 9'h050); put_byte(8'h68);
        @(negedge clk); cs_rise = 1; cs_on_boundary = 1;
        @(negedge clk); cs_rise = 0; cs_on_boundary = 0; wp_n = 0;
        repeat (WR + 4) @(negedge clk);
        wp_n = 1;
        check("R6 wp during busy writes", wr_count, 1);
        check("R6 wp during busy data", shadow[9'h050], 'h68);
    endtask

    task automatic t_lock_update();
        clear_log();
        open_xfer(1'b1, '0); put_byte(8'h05); put_byte(8'hF9);
        @(negedge clk); cs_rise = 1; cs_on_boundary = 1;
        @(negedge clk); cs_rise = 0; cs_on_boundary = 0;
        repeat (10) @(negedge clk);
        check("R9 code held during cycle", lock_code, 0);
        repeat (WR) @(negedge clk);
        check("R9 last byte low bits", lock_code, 1);
        check("R9 no array writes", wr_count, 0);
        check("R10 clear after lock", clr_cnt, 1);
    endtask

    task automatic t_lock_sweep();
        int addrs[6] = '{'h003, 'h085, 'h105, 'h185, 'h1F5, 'h075};
        for (int code = 0; code < 8; code++) begin
            set_lock(8'(code) | 8'h08);
            check("R9 code stored", lock_code, code);
            for (int k = 0; k < 6; k++) begin
                clear_log();
                open_xfer(1'b0, 9'(addrs[k]));
                put_byte(8'(code * 16 + k));
                close_xfer(1'b1);
                check($sformatf("R7 R8 code %0d addr %0h", code, addrs[k]),
                      wr_count, blocked(code, addrs[k]) ? 0 : 1);
            end
        end
        set_lock(8'h00);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        open_xfer(1'b0, 9'h0A0); put_byte(8'h77);
        @(negedge clk); cs_rise = 1; cs_on_boundary = 1;
        @(negedge clk); cs_rise = 0; cs_on_boundary = 0;
        open_xfer(1'b0, 9'h0C0); put_byte(8'h99);
        @(negedge clk); cs_rise = 1; cs_on_boundary = 1;
        @(negedge clk); cs_rise = 0; cs_on_boundary = 0;
        repeat (WR + 4) @(negedge clk);
        check("R11 writes", wr_count, 1);
        check("R11 address", first_addr, 'h0A0);
        check("R11 busy length", busy_cnt, WR);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_discard();
        t_wp();
        t_lock_update();
        t_lock_sweep();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule